// File: doc/BRIEF.md
# Trace Capture FIFO with Boundary-Aligned Core Stall

This block buffers trace words produced by a processor core and hands them to a narrow export port one word per cycle over a valid/ready handshake. A programmable almost-full watermark raises a full flag when the FIFO fills to that level. While the flag is up, a stall controller holds the core, so that trace coverage is not lost. The stall may only begin at an instruction boundary. A pending unmasked interrupt overrides it.

The core cannot stop in the middle of an instruction, and a multi-register transfer already under way keeps producing words. For this reason the watermark is always clamped to leave at least `SLACK` (16) free entries above it. A word that still finds the FIFO at full capacity is dropped, and a sticky overflow flag records the loss. A global enable turns all trace activity off. When it is low, nothing is captured and all trace outputs stay low, which saves power when trace is unused.

Top module: `trace_stall_fifo`

## Requirements
- R1: While `en` is low, no word is captured and `level` does not change. `out_valid` is low at once, and `full_flag` and `stall` are low from the next cycle.
- R2: Words leave `out_data` in the order they were accepted. When a push and a pop occur in the same cycle, `level` is unchanged.
- R3: `full_flag` is high one cycle after `level` is at or above the active watermark, and low one cycle after `level` is below it.
- R4: `stall` rises only in the cycle after one in which `insn_end` was high and `full_flag` was high. It stays high with no further boundary, and falls one cycle after `full_flag` falls.
- R5: Once `full_flag` rises, at least 16 further words are accepted without loss when nothing drains.
- R6: When `irq_pend` is high and the stored mask bit is 0, `stall` is low in the next cycle. When the mask bit is 1, a pending interrupt has no effect on the stall.
- R7: A control write (`cfg_we`) stores `cfg_irq_mask` and a watermark equal to `cfg_wmark` clamped to the range 1 to DEPTH-SLACK. After reset the watermark is DEPTH-SLACK (48) and the mask is 0.
- R8: A word offered while `level` equals DEPTH is dropped, and `overflow` is set from the next cycle. The flag stays set until a control write.
- R9: Synchronous reset empties the FIFO and clears `full_flag`, `stall` and `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global trace enable |
| cfg_we | input | 1 | Control write strobe; also clears overflow |
| cfg_wmark | input | AW+1 (7) | Requested watermark |
| cfg_irq_mask | input | 1 | 1 = interrupts do not override the stall |
| in_valid | input | 1 | Trace word offered by the core |
| in_data | input | W (32) | Trace word |
| insn_end | input | 1 | Core is at an instruction boundary this cycle |
| irq_pend | input | 1 | FIQ or IRQ pending at the core |
| out_valid | output | 1 | Export word available |
| out_data | output | W (32) | Export word |
| out_ready | input | 1 | Export sink accepts the word |
| full_flag | output | 1 | Occupancy at or above watermark (registered) |
| stall | output | 1 | Core hold request (registered) |
| overflow | output | 1 | Sticky word-loss flag |
| level | output | AW+1 (7) | Current occupancy |

## Verification
`level`, `out_valid` and `out_data` reflect a push or pop at the very edge that performs it. `full_flag` trails the level that causes it by one edge, and `stall` trails its cause, either the boundary or the flag falling, by one edge. Inputs are driven just after a rising edge and outputs are read just after the following edge, and every flag check is placed at the exact edge count that this chain gives. Drained words are compared at the falling edge against a queue of the words the bench expects to be kept.

// File: rtl/trace_stall_fifo.sv
module trace_stall_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int SLACK = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wmark,
  input  logic          cfg_irq_mask,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic          insn_end,
  input  logic          irq_pend,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic          full_flag,
  output logic          stall,
  output logic          overflow,
  output logic [CW-1:0] level
);
  localparam logic [CW-1:0] WM_MAX = CW'(DEPTH - SLACK);
  localparam logic [CW-1:0] CAP    = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, wm, wm_new;
  logic          irq_mask, full_q, stall_q, ovf_q;

  wire at_cap = (cnt == CAP);
  wire push   = en && in_valid && !at_cap;
  wire drop   = en && in_valid && at_cap;
  wire pop    = out_valid && out_ready;
  wire irq_block = irq_pend && !irq_mask;

  assign out_valid = en && (cnt != '0);
  assign out_data  = en ? mem[rptr] : '0;
  assign full_flag = full_q;
  assign stall     = stall_q;
  assign overflow  = ovf_q;
  assign level     = cnt;

  always_comb begin
    if (cfg_wmark > WM_MAX)      wm_new = WM_MAX;
    else if (cfg_wmark == '0)    wm_new = CW'(1);
    else                         wm_new = cfg_wmark;
  end

  always_ff @(posedge clk)
    if (push) mem[wptr] <= in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      wm       <= WM_MAX;
      irq_mask <= 1'b0;
      full_q   <= 1'b0;
      stall_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (cfg_we) begin
        wm       <= wm_new;
        irq_mask <= cfg_irq_mask;
      end
      full_q  <= en && (cnt >= wm);
      stall_q <= en && full_q && !irq_block && (stall_q || insn_end);
      ovf_q   <= drop || (ovf_q && !cfg_we);
    end
  end
endmodule

module trace_stall_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          cfg_we,
  input logic          in_valid,
  input logic          insn_end,
  input logic          irq_pend,
  input logic          out_valid,
  input logic          full_flag,
  input logic          stall,
  input logic          overflow,
  input logic [CW-1:0] level,
  input logic [CW-1:0] wm,
  input logic          irq_mask
);
  p_off_no_valid_r1: assert property (@(posedge clk) disable iff (rst)
    !en |-> !out_valid);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!full_flag && !stall));
  p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  p_flag_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (en && level >= wm) |=> full_flag);
  p_flag_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (level < wm) |=> !full_flag);
  p_stall_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(insn_end));
  p_stall_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
    stall |-> $past(full_flag));
  p_irq_release_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && !irq_mask) |=> !stall);
  p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
    (en && in_valid && level == CW'(DEPTH)) |=> overflow);
  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (overflow && !cfg_we) |=> overflow);
endmodule

bind trace_stall_fifo trace_stall_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .in_valid(in_valid),
  .insn_end(insn_end), .irq_pend(irq_pend), .out_valid(out_valid),
  .full_flag(full_flag), .stall(stall), .overflow(overflow), .level(level),
  .wm(wm), .irq_mask(irq_mask)
);

// File: tb/trace_stall_fifo_tb_top.sv
module trace_stall_fifo_tb_top;
  logic clk = 0, rst = 1, en = 0;
  logic cfg_we = 0, cfg_irq_mask = 0;
  logic [6:0] cfg_wmark = '0;
  logic in_valid = 0;
  logic [31:0] in_data = '0;
  logic insn_end = 0, irq_pend = 0, out_ready = 0;
  logic out_valid, full_flag, stall, overflow;
  logic [31:0] out_data;
  logic [6:0] level;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  bit timed_out = 0;

  always #4 clk = ~clk;

  trace_stall_fifo dut_i (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_wmark(cfg_wmark),
    .cfg_irq_mask(cfg_irq_mask), .in_valid(in_valid), .in_data(in_data),
    .insn_end(insn_end), .irq_pend(irq_pend), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .full_flag(full_flag),
    .stall(stall), .overflow(overflow), .level(level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: got %0h expected nothing", out_data);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (out_data !== e) begin
          n_fail++;
          $display("FAIL R2: got %0h expected %0h", out_data, e);
        end
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic push_word(input logic [31:0] d, input bit keep);
    tick();
    in_valid = 1; in_data = d;
    if (keep) exp_q.push_back(d);
    tick();
    in_valid = 0;
  endtask

  task automatic cfg(input logic [6:0] w, input logic m);
    tick();
    cfg_we = 1; cfg_wmark = w; cfg_irq_mask = m;
    tick();
    cfg_we = 0;
  endtask

  task automatic drain();
    out_ready = 1;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) tick();
    tick();
    out_ready = 0;
    chk("R2 drained", level, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    timed_out = 1;
  end

  initial begin : main
    fork
      begin
        repeat (3) tick();
        rst = 0; en = 1;
        tick();
        // R9 reset state
        chk("R9 level", level, 0);
        chk("R9 out_valid", out_valid, 0);
        chk("R9 full", full_flag, 0);
        chk("R9 stall", stall, 0);
        chk("R9 overflow", overflow, 0);

        // R2 ordering with held export
        for (int i = 0; i < 5; i++) push_word(32'hA000 + i, 1);
        chk("R2 level", level, 5);
        drain();

        // R2 simultaneous push/pop keeps level steady
        out_ready = 1;
        for (int i = 0; i < 10; i++) begin
          tick();
          in_valid = 1; in_data = 32'hB000 + i;
          exp_q.push_back(in_data);
          if (i >= 2) chk("R2 steady level", level, 1);
        end
        tick();
        in_valid = 0;
        drain();

        // R1 disabled: no capture, outputs quiet
        push_word(32'hC000, 1);
        push_word(32'hC001, 1);
        en = 0;
        push_word(32'hDEAD, 0);
        chk("R1 level held", level, 2);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 full", full_flag, 0);
        en = 1;
        drain();

        // R7 clamp high -> 48, R3 flag timing
        cfg(7'd100, 0);
        for (int i = 0; i < 47; i++) push_word(32'h1000 + i, 1);
        tick();
        chk("R3 below mark", full_flag, 0);
        push_word(32'h1000 + 47, 1);
        chk("R7 level at mark", level, 48);
        chk("R3 flag lags", full_flag, 0);
        tick();
        chk("R3 flag up", full_flag, 1);
        chk("R4 no boundary no stall", stall, 0);
        // R5 slack
        for (int i = 0; i < 16; i++) push_word(32'h2000 + i, 1);
        chk("R5 level full", level, 64);
        chk("R5 no loss", overflow, 0);
        chk("R4 still no stall", stall, 0);
        // R8 drop
        push_word(32'hBAD0, 0);
        chk("R8 level", level, 64);
        chk("R8 overflow", overflow, 1);
        repeat (3) tick();
        chk("R8 sticky", overflow, 1);
        // R4 boundary
        insn_end = 1;
        chk("R4 before edge", stall, 0);
        tick();
        insn_end = 0;
        chk("R4 stall up", stall, 1);
        repeat (3) tick();
        chk("R4 stall held", stall, 1);
        // R6 unmasked interrupt
        irq_pend = 1;
        tick();
        chk("R6 irq releases", stall, 0);
        insn_end = 1;
        repeat (2) tick();
        chk("R6 irq prevents", stall, 0);
        insn_end = 0;
        cfg(7'd48, 1);
        chk("R8 cleared by write", overflow, 0);
        insn_end = 1;
        tick();
        insn_end = 0;
        tick();
        chk("R6 masked stall", stall, 1);
        irq_pend = 0;
        // R4 release after flag falls
        out_ready = 1;
        begin
          bit seen = 0;
          for (int i = 0; i < 100 && !seen; i++) begin
            tick();
            if (level < 48) begin
              seen = 1;
              chk("R3 flag still up", full_flag, 1);
              chk("R4 stall still up", stall, 1);
              tick();
              chk("R3 flag down", full_flag, 0);
              chk("R4 stall lags", stall, 1);
              tick();
              chk("R4 stall down", stall, 0);
            end
          end
          chk("R3 level fell", seen, 1);
        end
        drain();

        // R7 clamp low -> 1
        cfg(7'd0, 0);
        push_word(32'h3000, 1);
        chk("R7 low lag", full_flag, 0);
        tick();
        chk("R7 low clamp", full_flag, 1);
        drain();
      end
      begin
        wait (timed_out);
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule